// File: doc/BRIEF.md
# Predicated Vector Load/Store Address Sequencer

This block walks through the elements of a single vector load or store and produces one effective address for every element that is active. A start pulse captures the operation's settings. These are the addressing mode, the immediate, the operand width code, the vector length, the base register index, the vector flags of the source and destination operands, and one predicate mask for each operand. The block then reads its base value from an integer register file through a combinational read port. It offers one element per cycle on a valid/ready handshake. Each element carries the address, the source element index and the destination element index.

The source and destination indices advance independently. An operand marked as a vector skips elements whose predicate bit is clear. An operand marked as scalar stays at index 0. The run ends when either index reaches the vector length, and a one-cycle done pulse marks the end. A fail-first request combined with indexed addressing is refused at start. A refused request issues no addresses and raises an error flag together with done.

Top module: `vls_agen`

## Requirements
- R1: While rst_ni is low, valid_o, done_o and ffirst_err_o are all low.
- R2: Mode 00 (scalar) gives every element the address rf[ra] + imm. All elements share that one address, while the vector destination index still steps through its active elements.
- R3: Mode 01 (unit stride) gives the address rf[ra] + (src_idx << opw). The opw codes 0, 1, 2 and 3 stand for 1, 2, 4 and 8 bytes.
- R4: Mode 10 (element stride) gives the address rf[ra] + src_idx * imm. The immediate is taken as two's complement and the sum wraps modulo 2^64.
- R5: Mode 11 (indexed) reads register (ra + src_idx) mod 32 through rf_addr_o and adds imm to it.
- R6: A vector operand's index moves past elements whose predicate bit is clear. A scalar operand ignores its predicate and its index stays 0.
- R7: When either index reaches the vector length, done_o is high for exactly one cycle with valid_o low. A vector length of 0, or a vector operand with no set predicate bit below the length, yields done with no element.
- R8: When neither operand is a vector, exactly one element is issued.
- R9: At most one element is issued per cycle. While valid_o is high and ready_i is low, addr_o, src_idx_o and dst_idx_o hold their values.
- R10: A start with ffirst_i high in mode 11 raises ffirst_err_o and done_o together in the next cycle and issues no element. With ffirst_i high in any other mode, the run is normal and ffirst_err_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; ignored while a run is in progress |
| mode_i | input | 2 | Addressing mode: 00 scalar, 01 unit stride, 10 element stride, 11 indexed |
| ffirst_i | input | 1 | Fail-first requested |
| src_vec_i | input | 1 | Source operand is a vector |
| dst_vec_i | input | 1 | Destination operand is a vector |
| ra_i | input | 5 | Base register index |
| imm_i | input | 64 | Immediate, two's complement |
| opw_i | input | 2 | Log2 of the operand width in bytes |
| vl_i | input | 7 | Vector length, 0 to 64 (larger values are clamped to 64) |
| src_pred_i | input | 64 | Source predicate mask |
| dst_pred_i | input | 64 | Destination predicate mask |
| rf_addr_o | output | 5 | Register file read index |
| rf_data_i | input | 64 | Register file read data (combinational) |
| valid_o | output | 1 | Element available |
| ready_i | input | 1 | Consumer accepts the element |
| addr_o | output | 64 | Effective address of the element |
| src_idx_o | output | 6 | Source element index |
| dst_idx_o | output | 6 | Destination element index |
| done_o | output | 1 | One-cycle end-of-run pulse |
| ffirst_err_o | output | 1 | Fail-first with indexed mode refused |

## Verification
Each addressing mode is run with a register file whose entries all differ. A wrong base register, a missing offset or a wrong scale therefore gives a distinct address. This also separates the wrap of the register index from the wrap of the 64-bit address. Predicate patterns include all-ones, sparse, empty, and ones that differ between source and destination. These show whether the skip, the independent advance of the two indices, and the end rule (which index runs out first) all work. Separate runs cover a scalar operand with a cleared predicate, both operands scalar, a stalled consumer, and fail-first in indexed and in strided modes. Together they tell ignored state from state that is actually used.

// File: rtl/vls_agen_pkg.sv
package vls_agen_pkg;
  typedef enum logic [1:0] {
    AM_SCALAR  = 2'b00,
    AM_UNIT    = 2'b01,
    AM_ESTRIDE = 2'b10,
    AM_INDEXED = 2'b11
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_REJ  = 2'b10
  } state_e;
endpackage

// File: rtl/vls_skip.sv
// Finds the first set predicate bit at or above from_i; N when there is none.
module vls_skip #(
  parameter int N  = 64,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  pred_i,
  input  logic [CW-1:0] from_i,
  input  logic          en_i,
  output logic [CW-1:0] idx_o
);
  always_comb begin
    idx_o = en_i ? CW'(N) : from_i;
    if (en_i) begin
      for (int k = N - 1; k >= 0; k--) begin
        if (pred_i[k] && (CW'(k) >= from_i)) idx_o = CW'(k);
      end
    end
  end
endmodule

// File: rtl/vls_ea.sv
module vls_ea
  import vls_agen_pkg::*;
#(
  parameter int AW  = 64,
  parameter int CW  = 7,
  parameter int RIW = 5
) (
  input  amode_e         mode_i,
  input  logic [CW-1:0]  idx_i,
  input  logic [AW-1:0]  imm_i,
  input  logic [1:0]     opw_i,
  input  logic [RIW-1:0] ra_i,
  output logic [RIW-1:0] rf_addr_o,
  input  logic [AW-1:0]  base_i,
  output logic [AW-1:0]  ea_o
);
  logic [AW-1:0] idx_ext;
  logic [AW-1:0] offs;

  assign idx_ext = AW'(idx_i);

  always_comb begin
    unique case (mode_i)
      AM_UNIT:    offs = idx_ext << opw_i;
      AM_ESTRIDE: offs = idx_ext * imm_i;
      default:    offs = imm_i;
    endcase
  end

  // indexed mode: the base register steps with the element, wrapping in the file
  assign rf_addr_o = (mode_i == AM_INDEXED) ? ra_i + idx_i[RIW-1:0] : ra_i;
  assign ea_o      = base_i + offs;
endmodule

// File: rtl/vls_agen.sv
module vls_agen
  import vls_agen_pkg::*;
#(
  parameter int AW    = 64,
  parameter int NREG  = 32,
  parameter int MAXVL = 64,
  localparam int RIW  = $clog2(NREG),
  localparam int IW   = $clog2(MAXVL),
  localparam int CW   = $clog2(MAXVL + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [1:0]      mode_i,
  input  logic            ffirst_i,
  input  logic            src_vec_i,
  input  logic            dst_vec_i,
  input  logic [RIW-1:0]  ra_i,
  input  logic [AW-1:0]   imm_i,
  input  logic [1:0]      opw_i,
  input  logic [CW-1:0]   vl_i,
  input  logic [MAXVL-1:0] src_pred_i,
  input  logic [MAXVL-1:0] dst_pred_i,
  output logic [RIW-1:0]  rf_addr_o,
  input  logic [AW-1:0]   rf_data_i,
  output logic            valid_o,
  input  logic            ready_i,
  output logic [AW-1:0]   addr_o,
  output logic [IW-1:0]   src_idx_o,
  output logic [IW-1:0]   dst_idx_o,
  output logic            done_o,
  output logic            ffirst_err_o
);
  state_e                 state_q;
  amode_e                 mode_q;
  logic                   src_vec_q, dst_vec_q, issued_q;
  logic [AW-1:0]          imm_q;
  logic [1:0]             opw_q;
  logic [CW-1:0]          vl_q;
  logic [RIW-1:0]         ra_q;
  logic [1:0][MAXVL-1:0]  pred_q;
  logic [1:0][CW-1:0]     cur_q;
  logic [1:0][CW-1:0]     found;
  logic [1:0]             vec_q;
  logic                   run, end_c, fire;

  assign vec_q = {dst_vec_q, src_vec_q};

  // index 0 = source side, index 1 = destination side
  for (genvar g = 0; g < 2; g++) begin : g_skip
    vls_skip #(.N(MAXVL), .CW(CW)) u_skip (
      .pred_i (pred_q[g]),
      .from_i (cur_q[g]),
      .en_i   (vec_q[g]),
      .idx_o  (found[g])
    );
  end

  vls_ea #(.AW(AW), .CW(CW), .RIW(RIW)) u_ea (
    .mode_i    (mode_q),
    .idx_i     (found[0]),
    .imm_i     (imm_q),
    .opw_i     (opw_q),
    .ra_i      (ra_q),
    .rf_addr_o (rf_addr_o),
    .base_i    (rf_data_i),
    .ea_o      (addr_o)
  );

  assign run   = (state_q == ST_RUN);
  assign end_c = (found[0] >= vl_q) || (found[1] >= vl_q) ||
                 (issued_q && !src_vec_q && !dst_vec_q);
  assign valid_o      = run && !end_c;
  assign done_o       = (run && end_c) || (state_q == ST_REJ);
  assign ffirst_err_o = (state_q == ST_REJ);
  assign fire         = valid_o && ready_i;
  assign src_idx_o    = found[0][IW-1:0];
  assign dst_idx_o    = found[1][IW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      mode_q    <= AM_SCALAR;
      src_vec_q <= 1'b0;
      dst_vec_q <= 1'b0;
      issued_q  <= 1'b0;
      imm_q     <= '0;
      opw_q     <= '0;
      vl_q      <= '0;
      ra_q      <= '0;
      pred_q    <= '0;
      cur_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mode_q    <= amode_e'(mode_i);
          src_vec_q <= src_vec_i;
          dst_vec_q <= dst_vec_i;
          imm_q     <= imm_i;
          opw_q     <= opw_i;
          vl_q      <= (vl_i > CW'(MAXVL)) ? CW'(MAXVL) : vl_i;
          ra_q      <= ra_i;
          pred_q    <= {dst_pred_i, src_pred_i};
          cur_q     <= '0;
          issued_q  <= 1'b0;
          state_q   <= (ffirst_i && amode_e'(mode_i) == AM_INDEXED) ? ST_REJ : ST_RUN;
        end
        ST_RUN: begin
          if (end_c) begin
            state_q <= ST_IDLE;
          end else if (fire) begin
            issued_q <= 1'b1;
            for (int s = 0; s < 2; s++) cur_q[s] <= found[s] + CW'(vec_q[s]);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vls_agen_chk.sv
module vls_agen_chk #(
  parameter int AW = 64,
  parameter int IW = 6,
  parameter int CW = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_o,
  input logic          ready_i,
  input logic [AW-1:0] addr_o,
  input logic [IW-1:0] src_idx_o,
  input logic [IW-1:0] dst_idx_o,
  input logic          done_o,
  input logic          ffirst_err_o,
  input logic [CW-1:0] vl_q,
  input logic          src_vec_q,
  input logic          dst_vec_q
);
  p_done_no_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o);

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_idx_in_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (CW'(src_idx_o) < vl_q) && (CW'(dst_idx_o) < vl_q));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) &&
                               $stable(src_idx_o) && $stable(dst_idx_o)));

  p_scalar_src_idx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !src_vec_q) |-> (src_idx_o == '0));

  p_scalar_dst_idx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !dst_vec_q) |-> (dst_idx_o == '0));

  p_err_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ffirst_err_o |-> (done_o && !valid_o));

  p_err_then_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ffirst_err_o |=> (!valid_o && !ffirst_err_o));
endmodule

bind vls_agen vls_agen_chk #(.AW(AW), .IW(IW), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_o      (valid_o),
  .ready_i      (ready_i),
  .addr_o       (addr_o),
  .src_idx_o    (src_idx_o),
  .dst_idx_o    (dst_idx_o),
  .done_o       (done_o),
  .ffirst_err_o (ffirst_err_o),
  .vl_q         (vl_q),
  .src_vec_q    (src_vec_q),
  .dst_vec_q    (dst_vec_q)
);

// File: tb/tb_vls_agen.sv
`timescale 1ns/1ps
module tb_vls_agen;
  localparam int NC = 10;

  typedef struct packed {
    logic [1:0]  mode;
    logic        sv;
    logic        dv;
    logic [63:0] imm;
    logic [1:0]  opw;
    logic [6:0]  vl;
    logic [63:0] sp;
    logic [63:0] dp;
    logic [4:0]  ra;
    logic [7:0]  ecnt;
    logic [63:0] efirst;
    logic [63:0] elast;
    logic [5:0]  esrc;
    logic [5:0]  edst;
  } vec_t;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  // register file model: rf[r] = 0x10000 + r*0x1000
  localparam vec_t CASES [NC] = '{
    '{2'd0, 1'b0, 1'b1, 64'd8, 2'd0, 7'd4, ONES, 64'hB, 5'd2, 8'd3, 64'h12008, 64'h12008, 6'd0, 6'd3},
    '{2'd0, 1'b0, 1'b0, 64'd8, 2'd0, 7'd4, ONES, ONES, 5'd2, 8'd1, 64'h12008, 64'h12008, 6'd0, 6'd0},
    '{2'd1, 1'b1, 1'b1, 64'd0, 2'd3, 7'd5, ONES, ONES, 5'd1, 8'd5, 64'h11000, 64'h11020, 6'd4, 6'd4},
    '{2'd2, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 2'd0, 7'd8, 64'hA4, ONES, 5'd0, 8'd3, 64'hFFE0, 64'hFF90, 6'd7, 6'd2},
    '{2'd3, 1'b1, 1'b1, 64'd4, 2'd0, 7'd4, ONES, ONES, 5'd30, 8'd4, 64'h2E004, 64'h11004, 6'd3, 6'd3},
    '{2'd1, 1'b1, 1'b1, 64'd0, 2'd0, 7'd4, 64'h0, ONES, 5'd0, 8'd0, 64'h0, 64'h0, 6'd0, 6'd0},
    '{2'd1, 1'b1, 1'b1, 64'd0, 2'd0, 7'd0, ONES, ONES, 5'd0, 8'd0, 64'h0, 64'h0, 6'd0, 6'd0},
    '{2'd1, 1'b1, 1'b0, 64'd0, 2'd1, 7'd3, ONES, 64'h0, 5'd3, 8'd3, 64'h13000, 64'h13004, 6'd2, 6'd0},
    '{2'd2, 1'b1, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 2'd0, 7'd3, 64'h4, ONES, 5'd31, 8'd1, 64'h2EFFE, 64'h2EFFE, 6'd2, 6'd0},
    '{2'd1, 1'b1, 1'b1, 64'd0, 2'd2, 7'd4, ONES, 64'h1, 5'd0, 8'd1, 64'h10000, 64'h10000, 6'd0, 6'd0}
  };
  localparam string TAGS [NC] = '{"R2", "R8", "R3", "R6", "R5", "R7", "R7", "R6", "R4", "R7"};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic        ffirst_i = 1'b0;
  logic        src_vec_i = 1'b0;
  logic        dst_vec_i = 1'b0;
  logic [4:0]  ra_i = '0;
  logic [63:0] imm_i = '0;
  logic [1:0]  opw_i = '0;
  logic [6:0]  vl_i = '0;
  logic [63:0] src_pred_i = '0;
  logic [63:0] dst_pred_i = '0;
  logic [4:0]  rf_addr_o;
  logic [63:0] rf_data_i;
  logic        valid_o;
  logic        ready_i = 1'b1;
  logic [63:0] addr_o;
  logic [5:0]  src_idx_o, dst_idx_o;
  logic        done_o, ffirst_err_o;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  assign rf_data_i = 64'h10000 + (64'(rf_addr_o) << 12);

  vls_agen dut (
    .clk_i, .rst_ni, .start_i, .mode_i, .ffirst_i, .src_vec_i, .dst_vec_i,
    .ra_i, .imm_i, .opw_i, .vl_i, .src_pred_i, .dst_pred_i,
    .rf_addr_o, .rf_data_i, .valid_o, .ready_i, .addr_o,
    .src_idx_o, .dst_idx_o, .done_o, .ffirst_err_o
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic load(input vec_t v, input bit ff);
    mode_i = v.mode; src_vec_i = v.sv; dst_vec_i = v.dv; imm_i = v.imm;
    opw_i = v.opw; vl_i = v.vl; src_pred_i = v.sp; dst_pred_i = v.dp;
    ra_i = v.ra; ffirst_i = ff;
  endtask

  task automatic run_case(input int c, input bit ff);
    vec_t v = CASES[c];
    int cnt = 0;
    bit seen_done = 1'b0, seen_err = 1'b0;
    logic [63:0] first = '0, last = '0;
    logic [5:0]  ls = '0, ld = '0;
    @(negedge clk_i);
    load(v, ff);
    ready_i = 1'b1;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int n = 0; n < 300; n++) begin
      if (ffirst_err_o) seen_err = 1'b1;
      if (done_o) begin seen_done = 1'b1; break; end
      if (valid_o) begin
        if (cnt == 0) first = addr_o;
        last = addr_o; ls = src_idx_o; ld = dst_idx_o;
        cnt++;
      end
      @(negedge clk_i);
    end
    chk(TAGS[c], "done reached", 64'(seen_done), 64'd1);
    chk(TAGS[c], "element count", 64'(cnt), 64'(v.ecnt));
    if (v.ecnt != 0) begin
      chk(TAGS[c], "first addr", first, v.efirst);
      chk(TAGS[c], "last addr", last, v.elast);
      chk(TAGS[c], "last src idx", 64'(ls), 64'(v.esrc));
      chk(TAGS[c], "last dst idx", 64'(ld), 64'(v.edst));
    end
    chk("R10", "no err on non-indexed/normal run", 64'(seen_err), 64'd0);
    @(negedge clk_i);
    chk("R7", "done single cycle", 64'(done_o), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk_i);
    chk("R1", "valid in reset", 64'(valid_o), 64'd0);
    chk("R1", "done in reset", 64'(done_o), 64'd0);
    chk("R1", "err in reset", 64'(ffirst_err_o), 64'd0);
    rst_ni = 1'b1;

    for (int c = 0; c < NC; c++) run_case(c, 1'b0);

    // R10: fail-first with unit stride runs normally
    run_case(2, 1'b1);

    // R10: fail-first with indexed mode is refused
    @(negedge clk_i);
    load(CASES[4], 1'b1);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R10", "err raised", 64'(ffirst_err_o), 64'd1);
    chk("R10", "done with err", 64'(done_o), 64'd1);
    chk("R10", "no element on refuse", 64'(valid_o), 64'd0);
    @(negedge clk_i);
    chk("R10", "err one cycle", 64'(ffirst_err_o), 64'd0);
    chk("R10", "no element after refuse", 64'(valid_o), 64'd0);

    // R9: stall holds the element, then one step per accepted cycle
    @(negedge clk_i);
    load(CASES[2], 1'b0);
    ready_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int s = 0; s < 3; s++) begin
      chk("R9", "valid held", 64'(valid_o), 64'd1);
      chk("R9", "addr held", addr_o, 64'h11000);
      chk("R9", "src idx held", 64'(src_idx_o), 64'd0);
      @(negedge clk_i);
    end
    ready_i = 1'b1;
    @(negedge clk_i);
    chk("R9", "next addr after accept", addr_o, 64'h11008);
    chk("R9", "next src idx after accept", 64'(src_idx_o), 64'd1);
    @(negedge clk_i);
    chk("R9", "third addr", addr_o, 64'h11010);
    repeat (4) @(negedge clk_i);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule